// File: doc/BRIEF.md
# Page-Table Refill Walker for TLB Misses

This block services a TLB miss in hardware. When a miss is handed to it, it builds the virtual address of the matching page-table entry by OR-ing the page-table base with the faulting address shifted right by ten bits, then clearing the two low bits. It translates that address through the TLB's lookup port. This lookup is a ring-0 data access with walking disabled, so a miss on it does not start a second walk. It then reads the 32-bit entry over a valid/ready memory port and writes a new mapping into one of four refill ways.

The refill way comes from a two-bit counter that is incremented before use. Only successful walks advance it. A successful walk also loads the fault address register with the faulting address. A walk fails if the entry's own address misses in the TLB or if the memory read returns an error. A failed walk writes nothing and returns the miss cause of the original access: one code for instruction fetch and another for load/store. Checking permissions on the final access is left to the caller.

Top module: `tlbw_walker`

## Requirements
- R1: Exactly one cycle after a miss is accepted, `lk_valid` is high for one cycle with `lk_vaddr` = ((`pt_base` | (`miss_vaddr` >> 10)) with bits [1:0] cleared).
- R2: If `lk_hit` is low during the lookup cycle, the walk ends with no memory request and no TLB write, and `done_ok` is 0.
- R3: The memory request address equals the `lk_paddr` sampled in the lookup cycle. Once raised, `mem_req_valid` and `mem_req_addr` stay unchanged until `mem_req_ready` is seen.
- R4: A response with `mem_rsp_err` high ends the walk with no TLB write and `done_ok` = 0.
- R5: On a failed walk, `done_cause` is `DATA_MISS_CAUSE` (default 24) when `miss_is_data` was 1 and `INST_MISS_CAUSE` (default 16) otherwise.
- R6: The write way is the refill counter plus one, modulo 4. The counter is 0 after reset, so successful walks use ways 1, 2, 3, 0, 1 and so on. Failed walks do not advance the counter.
- R7: A successful walk pulses `wr_en` for one cycle. The written fields are: tag = vaddr[31:12], index = vaddr[12 +: IDX_W], ppn = pte[31:12], attr = pte[3:0], and asid = byte pte[5:4] of `ring_asid` (byte n is bits [8n+7:8n]).
- R8: `excvaddr` is 0 after reset. It takes the faulting address in the cycle after a TLB write and is unchanged at all other times.
- R9: `busy` is high from the cycle after acceptance through the `done_valid` cycle. `done_valid` is a one-cycle pulse. While `busy` is high, `miss_valid` is ignored.
- R10: During and right after reset, `busy`, `wr_en`, `done_valid`, `mem_req_valid` and `lk_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Start a walk (taken when idle) |
| miss_vaddr | input | 32 | Faulting virtual address |
| miss_is_data | input | 1 | 1 = load/store miss, 0 = fetch miss |
| pt_base | input | 32 | Page-table virtual base |
| ring_asid | input | 32 | ASID per ring, one byte each |
| lk_valid | output | 1 | TLB lookup of the entry address |
| lk_vaddr | output | 32 | Entry virtual address |
| lk_hit | input | 1 | Lookup hit (same cycle) |
| lk_paddr | input | 32 | Lookup physical address |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Request accepted |
| mem_req_addr | output | 32 | Physical entry address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Page-table entry |
| mem_rsp_err | input | 1 | Read failed |
| wr_en | output | 1 | TLB refill write |
| wr_way | output | 2 | Refill way |
| wr_index | output | IDX_W | Entry index in the way |
| wr_tag | output | 20 | Virtual page number |
| wr_ppn | output | 20 | Physical page number |
| wr_asid | output | 8 | ASID of the new mapping |
| wr_attr | output | 4 | Attribute bits |
| excvaddr | output | 32 | Fault address register |
| busy | output | 1 | Walk in progress |
| done_valid | output | 1 | Walk finished |
| done_ok | output | 1 | Walk refilled the TLB |
| done_cause | output | CAUSE_W | Miss cause on failure |

## Verification
The assertions assume that the memory never returns a response unless a request is outstanding, and that `lk_hit` and `lk_paddr` are valid in the same cycle as `lk_valid`. The bench's memory model enforces both. It accepts at most one request, answers it after a latency of one or two cycles, and varies the number of request stall cycles from walk to walk. The lookup model is a fixed XOR mapping whose hit flag each walk sets for itself. Some walks also pulse a second miss while the block is busy, to confirm that it is ignored.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;
  typedef enum logic [2:0] {
    W_IDLE, W_XLATE, W_MREQ, W_MWAIT, W_WRITE, W_DONE
  } walk_state_t;

  // entry address in the virtually addressed page table, word aligned
  function automatic logic [31:0] pte_lookup_addr(input logic [31:0] base,
                                                  input logic [31:0] va);
    logic [31:0] a;
    a = base | (va >> 10);
    return {a[31:2], 2'b00};
  endfunction

  // ASID byte selected by a ring number
  function automatic logic [7:0] asid_for_ring(input logic [31:0] ra,
                                               input logic [1:0]  ring);
    return ra[8*ring +: 8];
  endfunction
endpackage

// File: rtl/tlbw_way_ctr.sv
module tlbw_way_ctr #(
  parameter int WAYS = 4,
  localparam int CW = $clog2(WAYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [CW-1:0] way
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (step) cnt_q <= cnt_q + 1'b1;
  end

  // pre-increment: the way used is the value the counter is about to take
  assign way = cnt_q + 1'b1;

  AST_WAY_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cnt_q == $past(cnt_q) + 1'b1); // R6
  AST_WAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/tlbw_entry_fmt.sv
module tlbw_entry_fmt
  import tlbw_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic [19:0]      va_page,
  input  logic [19:0]      pte_page,
  input  logic [5:0]       pte_low,
  input  logic [31:0]      ring_asid,
  output logic [19:0]      tag,
  output logic [IDX_W-1:0] index,
  output logic [19:0]      ppn,
  output logic [7:0]       asid,
  output logic [3:0]       attr
);
  assign tag   = va_page;
  assign index = va_page[IDX_W-1:0];
  assign ppn   = pte_page;
  assign asid  = asid_for_ring(ring_asid, pte_low[5:4]);
  assign attr  = pte_low[3:0];
endmodule

// File: rtl/tlbw_walker.sv
module tlbw_walker
  import tlbw_pkg::*;
#(
  parameter int IDX_W           = 3,
  parameter int CAUSE_W         = 6,
  parameter int INST_MISS_CAUSE = 16,
  parameter int DATA_MISS_CAUSE = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               miss_valid,
  input  logic [31:0]        miss_vaddr,
  input  logic               miss_is_data,
  input  logic [31:0]        pt_base,
  input  logic [31:0]        ring_asid,
  output logic               lk_valid,
  output logic [31:0]        lk_vaddr,
  input  logic               lk_hit,
  input  logic [31:0]        lk_paddr,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [31:0]        mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [31:0]        mem_rsp_data,
  input  logic               mem_rsp_err,
  output logic               wr_en,
  output logic [1:0]         wr_way,
  output logic [IDX_W-1:0]   wr_index,
  output logic [19:0]        wr_tag,
  output logic [19:0]        wr_ppn,
  output logic [7:0]         wr_asid,
  output logic [3:0]         wr_attr,
  output logic [31:0]        excvaddr,
  output logic               busy,
  output logic               done_valid,
  output logic               done_ok,
  output logic [CAUSE_W-1:0] done_cause
);
  localparam logic [CAUSE_W-1:0] CAUSE_I = CAUSE_W'(INST_MISS_CAUSE);
  localparam logic [CAUSE_W-1:0] CAUSE_D = CAUSE_W'(DATA_MISS_CAUSE);

  walk_state_t state_q, state_d;
  logic [31:0] vaddr_q, paddr_q, exc_q;
  logic [19:0] pte_page_q;
  logic [5:0]  pte_low_q;
  logic        is_data_q, ok_q;

  // named internal events
  logic start_ev, xlate_fail_ev, req_fire_ev, rsp_err_ev, rsp_ok_ev;
  assign start_ev      = (state_q == W_IDLE) && miss_valid;
  assign xlate_fail_ev = (state_q == W_XLATE) && !lk_hit;
  assign req_fire_ev   = (state_q == W_MREQ) && mem_req_ready;
  assign rsp_err_ev    = (state_q == W_MWAIT) && mem_rsp_valid && mem_rsp_err;
  assign rsp_ok_ev     = (state_q == W_MWAIT) && mem_rsp_valid && !mem_rsp_err;

  always_comb begin
    state_d = state_q;
    case (state_q)
      W_IDLE:  if (start_ev) state_d = W_XLATE;
      W_XLATE: state_d = lk_hit ? W_MREQ : W_DONE;
      W_MREQ:  if (req_fire_ev) state_d = W_MWAIT;
      W_MWAIT: if (rsp_err_ev) state_d = W_DONE;
               else if (rsp_ok_ev) state_d = W_WRITE;
      W_WRITE: state_d = W_DONE;
      W_DONE:  state_d = W_IDLE;
      default: state_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= W_IDLE;
      vaddr_q    <= '0;
      paddr_q    <= '0;
      exc_q      <= '0;
      pte_page_q <= '0;
      pte_low_q  <= '0;
      is_data_q  <= 1'b0;
      ok_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_ev) begin
        vaddr_q   <= miss_vaddr;
        is_data_q <= miss_is_data;
        ok_q      <= 1'b0;
      end
      if (state_q == W_XLATE && lk_hit) paddr_q <= lk_paddr;
      if (rsp_ok_ev) begin
        pte_page_q <= mem_rsp_data[31:12];
        pte_low_q  <= mem_rsp_data[5:0];
      end
      if (state_q == W_WRITE) begin
        exc_q <= vaddr_q;
        ok_q  <= 1'b1;
      end
    end
  end

  tlbw_way_ctr #(.WAYS(4)) u_ctr (
    .clk  (clk),
    .rst_n(rst_n),
    .step (wr_en),
    .way  (wr_way)
  );

  tlbw_entry_fmt #(.IDX_W(IDX_W)) u_fmt (
    .va_page  (vaddr_q[31:12]),
    .pte_page (pte_page_q),
    .pte_low  (pte_low_q),
    .ring_asid(ring_asid),
    .tag      (wr_tag),
    .index    (wr_index),
    .ppn      (wr_ppn),
    .asid     (wr_asid),
    .attr     (wr_attr)
  );

  assign lk_valid      = (state_q == W_XLATE);
  assign lk_vaddr      = pte_lookup_addr(pt_base, vaddr_q);
  assign mem_req_valid = (state_q == W_MREQ);
  assign mem_req_addr  = paddr_q;
  assign wr_en         = (state_q == W_WRITE);
  assign excvaddr      = exc_q;
  assign busy          = (state_q != W_IDLE);
  assign done_valid    = (state_q == W_DONE);
  assign done_ok       = ok_q;
  assign done_cause    = ok_q ? '0 : (is_data_q ? CAUSE_D : CAUSE_I);

  AST_LK_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> lk_vaddr[1:0] == 2'b00); // R1
  AST_LK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> !lk_valid); // R1
  AST_XLATE_MISS_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    xlate_fail_ev |=> done_valid && !mem_req_valid && !wr_en); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R3
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err_ev |=> !wr_en && done_valid); // R4
  AST_FAIL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !done_ok |-> (done_cause == CAUSE_D || done_cause == CAUSE_I)); // R5
  AST_EXC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(excvaddr)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid && !busy); // R9
  AST_WR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy); // R7
endmodule

// File: tb/test_tlbw_walker.sv
module test_tlbw_walker;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        miss_valid = 1'b0, miss_is_data = 1'b0;
  logic [31:0] miss_vaddr = '0, pt_base = '0, ring_asid = '0;
  logic        lk_valid, lk_hit;
  logic [31:0] lk_vaddr, lk_paddr;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        wr_en;
  logic [1:0]  wr_way;
  logic [IDX_W-1:0] wr_index;
  logic [19:0] wr_tag, wr_ppn;
  logic [7:0]  wr_asid;
  logic [3:0]  wr_attr;
  logic [31:0] excvaddr;
  logic        busy, done_valid, done_ok;
  logic [5:0]  done_cause;

  tlbw_walker #(.IDX_W(IDX_W)) i_tlbw_walker (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_vaddr(miss_vaddr),
    .miss_is_data(miss_is_data), .pt_base(pt_base), .ring_asid(ring_asid),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err), .wr_en(wr_en),
    .wr_way(wr_way), .wr_index(wr_index), .wr_tag(wr_tag), .wr_ppn(wr_ppn),
    .wr_asid(wr_asid), .wr_attr(wr_attr), .excvaddr(excvaddr), .busy(busy),
    .done_valid(done_valid), .done_ok(done_ok), .done_cause(done_cause)
  );

  int errors = 0, checks = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // lookup model: fixed page remap, hit chosen per walk
  logic hit_mode = 1'b1;
  assign lk_hit   = hit_mode;
  assign lk_paddr = {lk_vaddr[31:12] ^ 20'h5A5A5, lk_vaddr[11:0]};

  // memory model
  int   stall_cfg = 0, lat_cfg = 1, stall_left = 0, lat_left = 0;
  logic err_mode = 1'b0;
  logic [31:0] pte_val = '0, req_addr_seen = '0;
  int   req_count = 0;
  assign mem_req_ready = (stall_left == 0);

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (lat_left > 0) begin
      lat_left <= lat_left - 1;
      if (lat_left == 1) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= pte_val;
        mem_rsp_err   <= err_mode;
      end
    end else if (mem_req_valid) begin
      if (stall_left > 0) stall_left <= stall_left - 1;
      else begin
        req_addr_seen <= mem_req_addr;
        req_count++;
        lat_left <= lat_cfg;
      end
    end
  end

  // monitor
  int lk_count = 0, wr_count = 0, done_count = 0;
  logic [31:0] lk_seen;
  logic [1:0]  way_s; logic [IDX_W-1:0] idx_s;
  logic [19:0] tag_s, ppn_s; logic [7:0] asid_s; logic [3:0] attr_s;
  logic        ok_s; logic [5:0] cause_s;
  always @(posedge clk) begin
    if (lk_valid) begin lk_count++; lk_seen = lk_vaddr; end
    if (wr_en) begin
      wr_count++; way_s = wr_way; idx_s = wr_index; tag_s = wr_tag;
      ppn_s = wr_ppn; asid_s = wr_asid; attr_s = wr_attr;
    end
    if (done_valid) begin done_count++; ok_s = done_ok; cause_s = done_cause; end
  end

  int good_walks = 0;
  logic [31:0] exp_exc = '0;

  task automatic walk(input logic [31:0] va, input bit is_data,
                      input logic [31:0] pte, input bit hit, input bit err,
                      input int stall, input int lat, input bit poke);
    int lk0, wr0, dn0, rq0, t;
    logic [31:0] exp_lk, exp_pa;
    bit success;
    lk0 = lk_count; wr0 = wr_count; dn0 = done_count; rq0 = req_count;
    hit_mode = hit; err_mode = err; pte_val = pte;
    stall_cfg = stall; lat_cfg = lat; stall_left = stall;
    @(negedge clk);
    miss_vaddr = va; miss_is_data = is_data; miss_valid = 1'b1;
    @(negedge clk);
    miss_valid = 1'b0;
    chk(busy === 1'b1, "R9", "busy after accept", {31'b0, busy}, 1);
    if (poke) begin
      @(negedge clk);
      miss_vaddr = ~va; miss_valid = 1'b1;
      @(negedge clk);
      miss_valid = 1'b0;
    end
    t = 0;
    while (done_count == dn0 && t < 60) begin @(negedge clk); t++; end
    chk(t < 60, "R9", "walk completes", t, 0);
    chk(busy === 1'b0, "R9", "idle after done", {31'b0, busy}, 0);
    success = hit && !err;
    exp_lk = (pt_base | (va >> 10)) & 32'hFFFF_FFFC;
    exp_pa = {exp_lk[31:12] ^ 20'h5A5A5, exp_lk[11:0]};
    chk(lk_count == lk0 + 1, "R1", "one lookup", lk_count - lk0, 1);
    chk(lk_seen == exp_lk, "R1", "lookup address", lk_seen, exp_lk);
    chk(req_count == rq0 + (hit ? 1 : 0), "R2", "request count", req_count - rq0, hit);
    if (hit)
      chk(req_addr_seen == exp_pa, "R3", "request address", req_addr_seen, exp_pa);
    if (success) begin
      good_walks++;
      exp_exc = va;
      chk(wr_count == wr0 + 1, "R7", "one write", wr_count - wr0, 1);
      chk(way_s == 2'(good_walks), "R6", "refill way", way_s, 2'(good_walks));
      chk(tag_s == va[31:12], "R7", "tag", tag_s, va[31:12]);
      chk(idx_s == va[12 +: IDX_W], "R7", "index", idx_s, va[12 +: IDX_W]);
      chk(ppn_s == pte[31:12], "R7", "ppn", ppn_s, pte[31:12]);
      chk(attr_s == pte[3:0], "R7", "attr", attr_s, pte[3:0]);
      chk(asid_s == ring_asid[8*pte[5:4] +: 8], "R7", "asid", asid_s,
          ring_asid[8*pte[5:4] +: 8]);
      chk(ok_s === 1'b1, "R7", "done_ok", ok_s, 1);
    end else begin
      chk(wr_count == wr0, hit ? "R4" : "R2", "no write on failure", wr_count - wr0, 0);
      chk(ok_s === 1'b0, "R2", "done_ok low", ok_s, 0);
      chk(cause_s == (is_data ? 6'd24 : 6'd16), "R5", "cause", cause_s,
          is_data ? 24 : 16);
    end
    chk(excvaddr == exp_exc, "R8", "fault address", excvaddr, exp_exc);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk(!busy && !wr_en && !done_valid && !mem_req_valid && !lk_valid, "R10",
            "outputs in reset", {27'b0, busy, wr_en, done_valid, mem_req_valid, lk_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !wr_en && !done_valid && !mem_req_valid && !lk_valid, "R10",
            "outputs after reset", {27'b0, busy, wr_en, done_valid, mem_req_valid, lk_valid}, 0);
        chk(excvaddr == 0, "R8", "fault address reset", excvaddr, 0);
        pt_base   = 32'hC000_0000;
        ring_asid = 32'h44_33_22_11;
        for (int i = 0; i < 40; i++) begin
          logic [31:0] va, pte;
          bit hit, err;
          va  = {i[7:0] * 8'd37, 12'(i * 911), i[3:0] ^ 4'h9, 8'(i * 13)};
          pte = {20'(i * 4099 + 7), 6'(i), 2'(i / 3), 4'(i * 5)};
          hit = (i % 7) != 3;
          err = (i % 5) == 4;
          if (i == 20) ring_asid = 32'hA0_B1_C2_D3;
          if (i == 30) pt_base = 32'h8000_0000;
          walk(va, i[0], pte, hit, err, i % 3, 1 + i % 2, (i % 4) == 1);
        end
      end
      begin
        repeat (20000) @(negedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule